// File: doc/BRIEF.md
# Timer Compare Channel

This block is one compare channel that sits beside an 8-bit timer/counter. The counter's running value, its top and bottom pulses and the mode selection come in as inputs. An equality comparator checks the count against the active compare value on every cycle. A hit raises a sticky flag, which can request an interrupt, and drives a single waveform pin through a selectable hold, toggle, clear or set action. In clear-on-compare mode a hit also sends a clear request back to the counter.

A small register port gives software access to the channel. Address 0 holds the compare value. Writing it loads the active value at once in the non-PWM modes. In the PWM modes the write goes to a shadow copy, and the shadow moves into the active value at the top or bottom of the count sequence, whichever the update-select input chooses. Address 1 carries the flag, which is cleared by writing a one to it. The same address carries a force strobe that fires the pin action without a real hit. The counter itself, prescaling and complete PWM waveform generation are outside this block.

Top module: `cmp_channel`

## Requirements
- R1: `match_o` is high in the same cycle as `cnt_i` equals the active compare value, and low otherwise.
- R2: A cycle with `match_o` high sets `flag_o` at the following clock edge. `irq_o` is high exactly while `flag_o` and `ie_i` are both high.
- R3: A write to address 1 with data bit 0 set clears `flag_o` at the next edge. A write to address 1 with bit 0 at zero leaves the flag unchanged. Address 1 reads back the flag in bit 0, with every other bit zero.
- R4: `irq_ack_i` high clears `flag_o` at the next edge. If a real match occurs in the same cycle as an acknowledge or a clearing write, the flag is set.
- R5: In the non-PWM modes (`mode_i` 00 normal, 01 clear-on-compare), a write to address 0 replaces the active compare value at the next edge. Address 0 always reads the active value.
- R6: In the PWM modes (`mode_i` bit 1 set), a write to address 0 loads only the shadow register. The shadow is copied into the active value at the edge that closes a cycle with `top_i` high (when `upd_at_bot_i` is 0) or with `bot_i` high (when `upd_at_bot_i` is 1). The other event is ignored.
- R7: At the edge after a match, `pin_o` follows `act_i`: 00 holds its level, 01 toggles, 10 drives 0, 11 drives 1.
- R8: In the non-PWM modes, a write to address 1 with data bit 1 set applies the `act_i` action to `pin_o` at the next edge. A forced compare sets neither the flag nor `cnt_clr_o`.
- R9: In the PWM modes the force bit has no effect on `pin_o`. The force bit always reads back as 0.
- R10: `cnt_clr_o` is high in the same cycle as a real match while `mode_i` is 01, and is never high otherwise.
- R11: After reset the active value and the shadow are 0, and `flag_o` and `pin_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_i | input | 8 | Running counter value |
| top_i | input | 1 | Counter is at the top of its sequence |
| bot_i | input | 1 | Counter is at the bottom of its sequence |
| mode_i | input | 2 | 00 normal, 01 clear-on-compare, 1x PWM |
| upd_at_bot_i | input | 1 | Shadow commit event: 0 top, 1 bottom |
| act_i | input | 2 | Pin action on compare |
| ie_i | input | 1 | Interrupt enable |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears the flag |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational on address |
| match_o | output | 1 | Raw comparator hit |
| flag_o | output | 1 | Sticky compare flag |
| irq_o | output | 1 | Interrupt request |
| pin_o | output | 1 | Waveform output pin |
| cnt_clr_o | output | 1 | Clear request to the counter |

## Verification
The comparator hit, the clear request, the interrupt request and the read data are combinational, so they are due in the same cycle as the stimulus. The flag, the pin and the active compare value each change one clock edge later. The bench drives inputs on the falling edge and checks the combinational results 1 ns afterwards, against a reference model that holds the current state. It then advances the model across the rising edge and checks the registered results at the next falling edge. This keeps each result aligned with the cycle in which it is due.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    localparam logic [1:0] MODE_NORMAL = 2'b00;
    localparam logic [1:0] MODE_CTC    = 2'b01;

    localparam int ADDR_CMP  = 0;
    localparam int ADDR_CTL  = 1;
    localparam int FLAG_BIT  = 0;
    localparam int FORCE_BIT = 1;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } act_e;

    function automatic logic is_pwm(input logic [1:0] mode);
        return mode[1];
    endfunction

endpackage

// File: rtl/cmp_value_reg.sv
module cmp_value_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pwm_i,
    input  logic         commit_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] act_o
);
    typedef struct packed {
        logic [W-1:0] shadow;
        logic [W-1:0] act;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.shadow = wdata_i;
            if (!pwm_i) begin
                st_d.act = wdata_i;
            end
        end
        if (pwm_i && commit_i) begin
            st_d.act = st_q.shadow;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_o = st_q.act;
endmodule

// File: rtl/cmp_flag.sv
module cmp_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic clr_i,
    input  logic ack_i,
    input  logic ie_i,
    output logic flag_o,
    output logic irq_o
);
    typedef struct packed {
        logic flag;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i || ack_i) begin
            st_d.flag = 1'b0;
        end
        if (hit_i) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
    assign irq_o  = st_q.flag & ie_i;
endmodule

// File: rtl/cmp_pin.sv
module cmp_pin
    import cmp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire_i,
    input  logic [1:0] act_i,
    output logic       pin_o
);
    typedef struct packed {
        logic pin;
    } st_t;

    st_t  st_d, st_q;
    act_e act;

    always_comb begin
        act  = act_e'(act_i);
        st_d = st_q;
        if (fire_i) begin
            unique case (act)
                ACT_HOLD:   st_d.pin = st_q.pin;
                ACT_TOGGLE: st_d.pin = ~st_q.pin;
                ACT_CLEAR:  st_d.pin = 1'b0;
                ACT_SET:    st_d.pin = 1'b1;
                default:    st_d.pin = st_q.pin;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_o = st_q.pin;
endmodule

// File: rtl/cmp_channel.sv
module cmp_channel
    import cmp_pkg::*;
#(
    parameter int W  = 8,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  cnt_i,
    input  logic          top_i,
    input  logic          bot_i,
    input  logic [1:0]    mode_i,
    input  logic          upd_at_bot_i,
    input  logic [1:0]    act_i,
    input  logic          ie_i,
    input  logic          irq_ack_i,
    input  logic          reg_wr_i,
    input  logic [AW-1:0] reg_addr_i,
    input  logic [W-1:0]  reg_wdata_i,
    output logic [W-1:0]  reg_rdata_o,
    output logic          match_o,
    output logic          flag_o,
    output logic          irq_o,
    output logic          pin_o,
    output logic          cnt_clr_o
);
    localparam logic [AW-1:0] A_CMP = AW'(ADDR_CMP);
    localparam logic [AW-1:0] A_CTL = AW'(ADDR_CTL);

    logic         pwm;
    logic         commit;
    logic         cmp_wr;
    logic         clr_wr;
    logic         force_wr;
    logic         fire;
    logic [W-1:0] act_val;

    always_comb begin
        pwm      = is_pwm(mode_i);
        commit   = upd_at_bot_i ? bot_i : top_i;
        cmp_wr   = reg_wr_i && (reg_addr_i == A_CMP);
        clr_wr   = reg_wr_i && (reg_addr_i == A_CTL) && reg_wdata_i[FLAG_BIT];
        force_wr = reg_wr_i && (reg_addr_i == A_CTL) && reg_wdata_i[FORCE_BIT];
        match_o  = (cnt_i == act_val);
        fire     = match_o || (force_wr && !pwm);
        cnt_clr_o = match_o && (mode_i == MODE_CTC);
    end

    cmp_value_reg #(.W(W)) u_value (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwm_i    (pwm),
        .commit_i (commit),
        .wr_i     (cmp_wr),
        .wdata_i  (reg_wdata_i),
        .act_o    (act_val)
    );

    cmp_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit_i  (match_o),
        .clr_i  (clr_wr),
        .ack_i  (irq_ack_i),
        .ie_i   (ie_i),
        .flag_o (flag_o),
        .irq_o  (irq_o)
    );

    cmp_pin u_pin (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (fire),
        .act_i  (act_i),
        .pin_o  (pin_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == A_CMP) begin
            reg_rdata_o = act_val;
        end else if (reg_addr_i == A_CTL) begin
            reg_rdata_o[FLAG_BIT] = flag_o;
        end
    end
endmodule

// File: rtl/cmp_channel_sva.sv
module cmp_channel_sva #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   mode_i,
    input logic         top_i,
    input logic         bot_i,
    input logic         upd_at_bot_i,
    input logic         ie_i,
    input logic         irq_ack_i,
    input logic         cmp_wr,
    input logic         clr_wr,
    input logic         force_wr,
    input logic         match_o,
    input logic         flag_o,
    input logic         irq_o,
    input logic         pin_o,
    input logic         cnt_clr_o,
    input logic [W-1:0] act_val
);
    logic sel_evt;
    assign sel_evt = upd_at_bot_i ? bot_i : top_i;

    a_r2_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> flag_o);

    a_r2_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && ie_i) |-> irq_o);

    a_r3_clear_write: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !match_o) |=> !flag_o);

    a_r4_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack_i && !match_o) |=> !flag_o);

    a_r5_value_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_wr && !mode_i[1]) |=> $stable(act_val));

    a_r6_shadow_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i[1] && !sel_evt) |=> $stable(act_val));

    a_r8_force_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (force_wr && !flag_o && !match_o) |=> !flag_o);

    a_r8_force_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (force_wr && !match_o) |-> !cnt_clr_o);

    a_r9_force_pwm_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i[1] && force_wr && !match_o) |=> $stable(pin_o));

    a_r10_clear_req: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr_o |-> (match_o && mode_i == 2'b01));
endmodule

bind cmp_channel cmp_channel_sva #(.W(W)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .top_i        (top_i),
    .bot_i        (bot_i),
    .upd_at_bot_i (upd_at_bot_i),
    .ie_i         (ie_i),
    .irq_ack_i    (irq_ack_i),
    .cmp_wr       (cmp_wr),
    .clr_wr       (clr_wr),
    .force_wr     (force_wr),
    .match_o      (match_o),
    .flag_o       (flag_o),
    .irq_o        (irq_o),
    .pin_o        (pin_o),
    .cnt_clr_o    (cnt_clr_o),
    .act_val      (act_val)
);

// File: tb/cmp_channel_test.sv
module cmp_channel_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] cnt;
    logic       top, bot, upd_bot, ie, ack, wr;
    logic [1:0] mode, act, addr;
    logic [7:0] wdata, rdata;
    logic       match, flag, irq, pin, cclr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] m_act, m_shadow;
    logic       m_flag, m_pin;

    always #4 clk = ~clk;

    cmp_channel uut (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .top_i(top), .bot_i(bot),
        .mode_i(mode), .upd_at_bot_i(upd_bot), .act_i(act), .ie_i(ie),
        .irq_ack_i(ack), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .match_o(match), .flag_o(flag), .irq_o(irq),
        .pin_o(pin), .cnt_clr_o(cclr)
    );

    task automatic chk(string tag, string sig, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0h exp %0h", tag, sig, got, exp);
        end
    endtask

    // One clock of the reference model: check current outputs, then advance.
    task automatic cycle(string tag);
        logic       mm, pwm, evt, fire;
        logic [7:0] exp_rd, na, ns;
        logic       nf, np;
        #1;
        mm  = (cnt == m_act);
        pwm = mode[1];
        exp_rd = (addr == 2'd0) ? m_act : (addr == 2'd1) ? {7'd0, m_flag} : 8'd0;
        chk(tag, "match", match, mm);
        chk(tag, "cnt_clr", cclr, mm && (mode == 2'b01));
        chk(tag, "rdata", rdata, exp_rd);
        chk(tag, "flag", flag, m_flag);
        chk(tag, "irq", irq, m_flag && ie);
        chk(tag, "pin", pin, m_pin);
        evt = upd_bot ? bot : top;
        na = m_act; ns = m_shadow; nf = m_flag; np = m_pin;
        if (wr && addr == 2'd0) begin
            ns = wdata;
            if (!pwm) na = wdata;
        end
        if (pwm && evt) na = m_shadow;
        if ((wr && addr == 2'd1 && wdata[0]) || ack) nf = 1'b0;
        if (mm) nf = 1'b1;
        fire = mm || (wr && addr == 2'd1 && wdata[1] && !pwm);
        if (fire) begin
            case (act)
                2'b01: np = ~m_pin;
                2'b10: np = 1'b0;
                2'b11: np = 1'b1;
                default: np = m_pin;
            endcase
        end
        @(posedge clk);
        m_act = na; m_shadow = ns; m_flag = nf; m_pin = np;
        @(negedge clk);
    endtask

    task automatic wreg(logic [1:0] a, logic [7:0] d, string tag);
        wr = 1'b1; addr = a; wdata = d;
        cycle(tag);
        wr = 1'b0; wdata = 8'h00;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog run got hung exp finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cnt = 8'h55; top = 0; bot = 0; upd_bot = 0; ie = 1;
        ack = 0; wr = 0; mode = 2'b00; act = 2'b01; addr = 2'd0; wdata = 8'h00;
        m_act = 8'h00; m_shadow = 8'h00; m_flag = 1'b0; m_pin = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        cycle("R11");
        // R5: immediate write in normal mode, read back
        wreg(2'd0, 8'h20, "R5");
        cycle("R5");
        // R1 R2 R7: sweep through the compare value, toggle action
        for (int v = 8'h1E; v <= 8'h22; v++) begin cnt = 8'(v); cycle("R1"); end
        cnt = 8'h50;
        addr = 2'd1; cycle("R2");
        // R3: zero write keeps flag, one write clears
        wreg(2'd1, 8'h00, "R3");
        addr = 2'd1; cycle("R3");
        wreg(2'd1, 8'h01, "R3");
        addr = 2'd1; cycle("R3");
        // R4: acknowledge clears, match wins over clear
        cnt = 8'h20; cycle("R2");
        cnt = 8'h21; ack = 1; cycle("R4");
        ack = 0; cycle("R4");
        cnt = 8'h20; wreg(2'd1, 8'h01, "R4");
        cnt = 8'h21; ack = 1; cnt = 8'h20; cycle("R4");
        ack = 0; cnt = 8'h50; addr = 2'd1; cycle("R4");
        wreg(2'd1, 8'h01, "R4");
        // R7 R8: forced compare with each action in normal mode
        act = 2'b11; wreg(2'd1, 8'h02, "R8"); addr = 2'd1; cycle("R8");
        act = 2'b00; wreg(2'd1, 8'h02, "R8"); cycle("R7");
        act = 2'b10; wreg(2'd1, 8'h02, "R8"); cycle("R7");
        act = 2'b01; wreg(2'd1, 8'h02, "R8"); cycle("R8");
        wreg(2'd1, 8'h02, "R8"); cycle("R8");
        // R10: clear request in clear-on-compare mode only on real match
        mode = 2'b01;
        for (int v = 8'h1F; v <= 8'h21; v++) begin cnt = 8'(v); cycle("R10"); end
        cnt = 8'h50; wreg(2'd1, 8'h02, "R10"); cycle("R10");
        wreg(2'd1, 8'h01, "R10");
        // R6: shadow in PWM mode, commit at top
        mode = 2'b10; upd_bot = 0;
        wreg(2'd0, 8'h40, "R6");
        addr = 2'd0; cycle("R6");
        bot = 1; cycle("R6"); bot = 0;
        top = 1; cycle("R6"); top = 0;
        cycle("R6");
        // R6: commit at bottom, top ignored
        upd_bot = 1;
        wreg(2'd0, 8'h60, "R6");
        top = 1; cycle("R6"); top = 0;
        bot = 1; cycle("R6"); bot = 0;
        cycle("R6");
        cnt = 8'h60; cycle("R1"); cnt = 8'h50; cycle("R7");
        // R9: force ignored in PWM, force bit reads zero
        mode = 2'b11; act = 2'b01;
        wreg(2'd1, 8'h02, "R9");
        addr = 2'd1; cycle("R9");
        wreg(2'd1, 8'h03, "R9");
        addr = 2'd2; cycle("R9");
        addr = 2'd0; cycle("R9");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule